// File: doc/BRIEF.md
# Sector Word Counter with Overflow Latch

This block keeps a tally of the 36-bit data words moved during one disk sector and stops at 128. Each transferred word produces at most one increment. That increment can come from a write-side qualifier set or from a read-side qualifier set. When the 128th word arrives, the count rolls over to zero and a sticky overflow flag is raised. While the flag is set, the counter ignores further increments. As a result, the longitudinal parity word that follows the data words is never counted.

Four sources can clear the block:
- the falling edge of the selected unit's sector pulse
- a system or power clear
- a status-clear command
- a pulse issued after certain load or continue commands

All edges are found synchronously in the block clock domain. No clock is ever derived from a strobe.

The core is a two-state machine:
- `ST_COUNT`: the count advances.
- `ST_CAPPED`: the overflow flag reads 1 and the count is frozen.

It has three named transitions:
- `T_STEP`: stay in `ST_COUNT` and add one.
- `T_CAP`: go from `ST_COUNT` to `ST_CAPPED` on an increment at count 127.
- `T_CLEAR`: go from any state to `ST_COUNT` with the count at 0.

Top module: `sector_word_counter`

## Requirements
- R1: Each qualified increment taken in `ST_COUNT` raises `word_count` by exactly one on the next clock edge.
- R2: An increment taken while `word_count` is 127 (all seven bits 1) sets `overflow` to 1 and wraps `word_count` to 0 on the same edge.
- R3: The write-side term is active in a cycle where `wr_word_done`, `wr_clk_dly` and both bits of `fmt_phase` (value 2'b11) are all 1. A `fmt_phase` of any other value gives no increment.
- R4: The read-side term is active in a cycle where `rd_data_field` is 1 and `rd_xfer_strobe` is 0 after being 1 on the previous clock edge. A rising edge, or a falling edge with `rd_data_field` at 0, gives no increment.
- R5: The two terms are ORed. If both are active in the same cycle, the count rises by one, not two.
- R6: While `overflow` is 1, increments are ignored and `word_count` holds its value.
- R7: Any of the following sets both `word_count` and `overflow` to 0 on the next edge:
  - a 1 on `sys_clear`, `status_clear` or `cmd_clear`
  - `sector_pulse` reading 0 after reading 1 on the previous edge

  A rising edge of `sector_pulse` does not clear.
- R8: When a clear and an increment occur in the same cycle, the clear wins and the count ends at 0.
- R9: After an asynchronous reset (`rst_n` low), `word_count` is 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_word_done | input | 1 | Write: end of a word written |
| wr_clk_dly | input | 1 | Write: delayed clock qualifier |
| fmt_phase | input | 2 | Format generator state; 2'b11 is the data state |
| rd_data_field | input | 1 | Read: inside the data field |
| rd_xfer_strobe | input | 1 | Read: shift-to-buffer transfer strobe; its falling edge counts |
| sector_pulse | input | 1 | Selected unit sector pulse; its falling edge clears |
| sys_clear | input | 1 | System, power or IO reset clear |
| status_clear | input | 1 | Clear-status command |
| cmd_clear | input | 1 | Delayed pulse after load or continue commands |
| word_count | output | 7 | Words counted in the current sector |
| overflow | output | 1 | Sticky flag: 128 words reached |

## Verification
A corrupted state register shows up one cycle later, either as `overflow` set while the count is below 128 words or as `overflow` clear after the 128th word. A missed cap lets the parity word be counted, so `word_count` reads 1 instead of 0 on the cycle after that word. An edge register that holds a stale value makes the read-side increment or the sector-pulse clear fire one cycle late or twice. The reference model catches this on the next comparison. The bench compares both outputs against the model on every clock, so any divergence is reported within one cycle of its cause.

// File: rtl/sector_wc_pkg.sv
package sector_wc_pkg;
    typedef enum logic {
        ST_COUNT  = 1'b0,
        ST_CAPPED = 1'b1
    } wc_state_e;
endpackage

// File: rtl/wc_fall_detect.sv
module wc_fall_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] fall
);
    logic [N-1:0] sig_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sig_q[i] <= 1'b0;
            else        sig_q[i] <= sig_in[i];
        end
        assign fall[i] = sig_q[i] & ~sig_in[i];
    end

    // R4 / R7 edge detection: a reported fall needs a 1 held on the previous edge
    p_fall_needs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall[0] |-> ($past(sig_in[0]) && !sig_in[0]));
endmodule

// File: rtl/wc_inc_qualify.sv
module wc_inc_qualify #(
    parameter int FMT_W = 2
) (
    input  logic             wr_word_done,
    input  logic             wr_clk_dly,
    input  logic [FMT_W-1:0] fmt_phase,
    input  logic             rd_data_field,
    input  logic             rd_strobe_fall,
    output logic             inc
);
    localparam logic [FMT_W-1:0] FMT_DATA = '1;

    logic inc_wr;
    logic inc_rd;

    always_comb begin
        inc_wr = wr_word_done & wr_clk_dly & (fmt_phase == FMT_DATA);
        inc_rd = rd_data_field & rd_strobe_fall;
        inc    = inc_wr | inc_rd;
    end
endmodule

// File: rtl/wc_clear_merge.sv
module wc_clear_merge (
    input  logic sector_fall,
    input  logic sys_clear,
    input  logic status_clear,
    input  logic cmd_clear,
    output logic clr
);
    always_comb clr = sector_fall | sys_clear | status_clear | cmd_clear;
endmodule

// File: rtl/wc_count_fsm.sv
module wc_count_fsm
    import sector_wc_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             capped
);
    localparam logic [CNT_W-1:0] CNT_FULL = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    wc_state_e        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_COUNT;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // transitions: T_CLEAR, T_STEP, T_CAP
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (clr) begin
            st_n  = ST_COUNT;
            cnt_n = '0;
        end else begin
            unique case (st)
                ST_COUNT: begin
                    if (inc) begin
                        cnt_n = cnt + CNT_ONE;
                        if (cnt == CNT_FULL) st_n = ST_CAPPED;
                    end
                end
                ST_CAPPED: begin
                    cnt_n = cnt;
                end
                default: st_n = ST_COUNT;
            endcase
        end
    end

    // outputs
    always_comb begin
        count  = cnt;
        capped = (st == ST_CAPPED);
    end

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !capped) |=> (count == CNT_W'($past(count) + CNT_ONE)));
    p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !capped && count == CNT_FULL) |=> (capped && count == '0));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (capped && !clr) |=> (capped && $stable(count)));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !capped));
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(count));
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |-> (count == '0 && !capped));
endmodule

// File: rtl/sector_word_counter.sv
module sector_word_counter #(
    parameter int CNT_W = 7,
    parameter int FMT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_word_done,
    input  logic             wr_clk_dly,
    input  logic [FMT_W-1:0] fmt_phase,
    input  logic             rd_data_field,
    input  logic             rd_xfer_strobe,
    input  logic             sector_pulse,
    input  logic             sys_clear,
    input  logic             status_clear,
    input  logic             cmd_clear,
    output logic [CNT_W-1:0] word_count,
    output logic             overflow
);
    localparam int EDGES = 2;

    logic [EDGES-1:0] edge_in, edge_fall;
    logic             inc, clr;

    assign edge_in = {sector_pulse, rd_xfer_strobe};

    wc_fall_detect #(.N(EDGES)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (edge_in),
        .fall   (edge_fall)
    );

    wc_inc_qualify #(.FMT_W(FMT_W)) u_qual (
        .wr_word_done   (wr_word_done),
        .wr_clk_dly     (wr_clk_dly),
        .fmt_phase      (fmt_phase),
        .rd_data_field  (rd_data_field),
        .rd_strobe_fall (edge_fall[0]),
        .inc            (inc)
    );

    wc_clear_merge u_clr (
        .sector_fall  (edge_fall[1]),
        .sys_clear    (sys_clear),
        .status_clear (status_clear),
        .cmd_clear    (cmd_clear),
        .clr          (clr)
    );

    wc_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (inc),
        .clr    (clr),
        .count  (word_count),
        .capped (overflow)
    );

    // R8: clear beats a simultaneous increment
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (word_count == '0));
endmodule

// File: tb/sector_word_counter_tb.sv
`timescale 1ns/1ps
module sector_word_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_word_done = 0, wr_clk_dly = 0, rd_data_field = 0;
    logic       rd_xfer_strobe = 0, sector_pulse = 0;
    logic       sys_clear = 0, status_clear = 0, cmd_clear = 0;
    logic [1:0] fmt_phase = 2'b00;
    logic [6:0] word_count;
    logic       overflow;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R9";
    int    m_cnt = 0, m_ovf = 0, m_prev_sr = 0, m_prev_sp = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    sector_word_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_word_done(wr_word_done), .wr_clk_dly(wr_clk_dly),
        .fmt_phase(fmt_phase), .rd_data_field(rd_data_field), .rd_xfer_strobe(rd_xfer_strobe),
        .sector_pulse(sector_pulse), .sys_clear(sys_clear), .status_clear(status_clear),
        .cmd_clear(cmd_clear), .word_count(word_count), .overflow(overflow)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_prev_sr = 0; m_prev_sp = 0;
        end else begin
            int wr, rd, cl;
            wr = (wr_word_done && wr_clk_dly && fmt_phase == 2'b11) ? 1 : 0;
            rd = (rd_data_field && m_prev_sr == 1 && !rd_xfer_strobe) ? 1 : 0;
            cl = (sys_clear || status_clear || cmd_clear ||
                  (m_prev_sp == 1 && !sector_pulse)) ? 1 : 0;
            if (cl != 0) begin
                m_cnt = 0; m_ovf = 0;
            end else if ((wr != 0 || rd != 0) && m_ovf == 0) begin
                if (m_cnt == 127) begin m_cnt = 0; m_ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            m_prev_sr = rd_xfer_strobe ? 1 : 0;
            m_prev_sp = sector_pulse ? 1 : 0;
        end
    end

    task automatic check_now();
        n_vec++;
        if (int'(word_count) != m_cnt || int'(overflow) != m_ovf) begin
            n_bad++;
            $display("FAIL %s: count=%0d ovf=%0d expected count=%0d ovf=%0d",
                     cur_req, word_count, overflow, m_cnt, m_ovf);
        end
    endtask

    always @(negedge clk) if (rst_n) check_now();

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic idle();
        wr_word_done = 0; wr_clk_dly = 0; fmt_phase = 2'b00; rd_data_field = 0;
        sys_clear = 0; status_clear = 0; cmd_clear = 0;
    endtask

    task automatic wr_word(logic [1:0] f);
        wr_word_done = 1; wr_clk_dly = 1; fmt_phase = f; step(1); idle(); step(1);
    endtask

    task automatic rd_word(logic df);
        rd_data_field = df; rd_xfer_strobe = 1; step(1); rd_xfer_strobe = 0; step(1);
        rd_data_field = 0; step(1);
    endtask

    initial begin
        // R9 reset state
        #12;
        n_vec++;
        if (word_count !== 7'd0 || overflow !== 1'b0) begin
            n_bad++;
            $display("FAIL R9: count=%0d ovf=%0d expected 0/0", word_count, overflow);
        end
        @(posedge clk); #2 rst_n = 1;
        step(2);

        cur_req = "R3";
        wr_word(2'b11); wr_word(2'b10); wr_word(2'b01);
        wr_word_done = 1; wr_clk_dly = 0; fmt_phase = 2'b11; step(1); idle(); step(1);
        wr_word(2'b11);

        cur_req = "R4";
        rd_word(1); rd_word(0); rd_word(1);
        rd_data_field = 1; rd_xfer_strobe = 0; step(1); rd_xfer_strobe = 1; step(2);
        rd_xfer_strobe = 0; rd_data_field = 0; step(2);

        cur_req = "R5";
        rd_data_field = 1; rd_xfer_strobe = 1; step(1);
        rd_xfer_strobe = 0; wr_word_done = 1; wr_clk_dly = 1; fmt_phase = 2'b11;
        step(1); idle(); step(1);

        cur_req = "R7";
        sector_pulse = 1; step(2); sector_pulse = 0; step(2);

        cur_req = "R1";
        for (int i = 0; i < 127; i++) begin
            wr_word_done = 1; wr_clk_dly = 1; fmt_phase = 2'b11; step(1);
        end
        idle(); step(1);
        cur_req = "R2";
        wr_word(2'b11);
        cur_req = "R6";
        wr_word(2'b11); rd_word(1); wr_word(2'b11);

        cur_req = "R7";
        sys_clear = 1; step(1); idle(); step(1);
        wr_word(2'b11); wr_word(2'b11);
        status_clear = 1; step(1); idle(); wr_word(2'b11);
        cmd_clear = 1; step(1); idle(); step(1);
        wr_word(2'b11);

        cur_req = "R8";
        sys_clear = 1; wr_word_done = 1; wr_clk_dly = 1; fmt_phase = 2'b11; step(1);
        idle(); step(1);
        wr_word(2'b11);
        rd_data_field = 1; rd_xfer_strobe = 1; sector_pulse = 1; step(1);
        rd_xfer_strobe = 0; sector_pulse = 0; step(1); idle(); step(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule